// File: doc/BRIEF.md
# Serial Port Register and Interrupt Front End

This block is the register-side half of a serial port. A processor reaches it over a simple 32-bit register bus with word addresses. Through that bus it sets the frame format and bit period, loads characters into a 16-entry transmit queue and drains a 16-entry receive queue. It also reads queue occupancy flags and handles eight sticky interrupt causes. The serial bit engines sit outside. They take the frame settings from dedicated outputs, pull transmit characters through a valid/ready pair, and push received characters, with their error flags, through a single-cycle strobe.

Every received character read back over the bus carries a valid flag above the character bits. This lets software drain the receive queue without reading the occupancy flags first. The interrupt causes latch until software writes ones to them. Two of them, transmit queue empty and receive queue not empty, are level conditions: they keep setting for as long as their condition holds. One level interrupt line reports any latched cause whose enable bit is set. Clearing the global enable empties both queues and holds the engines idle.

Top module: `uart_fe`

## Requirements
- R1: After reset the configuration and interrupt enable words read 0 and `irq_o` is low. The info word (word address 6) reads 0x0A, and the status word (word address 9) reads 0x20.
- R2: The configuration word (word address 0) reads back as written. Its fields are: bits [1:0] data length code (0..3 means 5..8 bits), bit 2 two stop bits, bit 3 even parity, bit 4 parity enable, bit 5 transmit enable, bit 6 receive enable, bit 7 global enable, and bits [31:8] the bit period in clock cycles. These fields drive `cfg_*_o`. `tx_en_o` and `rx_en_o` are the transmit and receive enables ANDed with the global enable.
- R3: A write to transmit data (word address 4) queues bits [7:0]. `tx_valid_o` is high when the queue is not empty and both transmit enable and global enable are set. Characters leave on `tx_data_o` in write order, one for each cycle with `tx_valid_o` and `tx_ready_i` both high.
- R4: A write to transmit data while 16 characters are queued is dropped and latches status bit 0.
- R5: A read of receive data (word address 5) from a non-empty queue returns the oldest character in bits [7:0] with bit 8 set, then removes it. The order of characters is preserved.
- R6: A read of receive data from an empty queue returns 0, with bit 8 clear, and latches status bit 4.
- R7: A received strobe while 16 characters are waiting is dropped and latches status bit 3.
- R8: A received strobe with its stop error, parity error or break flag latches status bit 1, 2 or 7 respectively.
- R9: The info word reports bit 0 receive full, bit 1 receive empty, bit 2 transmit full and bit 3 transmit empty.
- R10: Writing the status word clears exactly the bits written as one. All other bits keep their value.
- R11: Status bit 5 (transmit empty) and bit 6 (receive not empty) are set on every cycle their condition holds, so they come back after a clear while the condition remains.
- R12: The interrupt enable word (word address 7) uses the status bit positions. `irq_o` is high when any status bit is set together with its enable bit. The pending word (word address 11) reads status AND enable.
- R13: While the global enable is clear, both queues are empty, `tx_valid_o` is low, received strobes and transmit data writes are ignored, and the info word reads 0x0A.
- R14: The sample-point word (word address 2) stores its low 16 bits, drives `sample_o` and reads back with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Bus write (1) or read (0) |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | 1 | Level interrupt |
| cfg_len_o | output | 2 | Data length code |
| cfg_stop2_o | output | 1 | Two stop bits |
| cfg_par_en_o | output | 1 | Parity enable |
| cfg_par_even_o | output | 1 | Even parity |
| cfg_div_o | output | 24 | Clock cycles per bit |
| tx_en_o | output | 1 | Transmit engine enable |
| rx_en_o | output | 1 | Receive engine enable |
| sample_o | output | 16 | Receive sample point |
| tx_valid_o | output | 1 | Transmit character available |
| tx_data_o | output | 8 | Transmit character |
| tx_ready_i | input | 1 | Engine takes the character |
| rx_valid_i | input | 1 | Received character strobe |
| rx_data_i | input | 8 | Received character |
| rx_stop_err_i | input | 1 | Stop bit error with strobe |
| rx_par_err_i | input | 1 | Parity error with strobe |
| rx_break_i | input | 1 | Break with strobe |

## Verification
Bus read data appears one cycle after the access, and a write takes effect at the edge where it is accepted. The bench therefore drives each access for one cycle from a falling edge and samples `rdata_o` at the next falling edge. The configuration outputs, `tx_valid_o`, `tx_data_o` and `irq_o` follow register state through logic only, so they are checked at the falling edge after the edge that changed that state. A level cause needs one edge more: its condition is taken from the queue count before the edge. Expected status words are reached only through a separate bus read, which always lands after that edge.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CHAR_W = 8;
  localparam int unsigned NCAUSE = 8;

  localparam logic [3:0] A_CFG  = 4'd0;
  localparam logic [3:0] A_SMP  = 4'd2;
  localparam logic [3:0] A_TXD  = 4'd4;
  localparam logic [3:0] A_RXD  = 4'd5;
  localparam logic [3:0] A_INFO = 4'd6;
  localparam logic [3:0] A_IE   = 4'd7;
  localparam logic [3:0] A_STAT = 4'd9;
  localparam logic [3:0] A_PEND = 4'd11;

  localparam int unsigned C_TX_OVR  = 0;
  localparam int unsigned C_RX_STOP = 1;
  localparam int unsigned C_RX_PAR  = 2;
  localparam int unsigned C_RX_OVR  = 3;
  localparam int unsigned C_RX_UND  = 4;
  localparam int unsigned C_TX_EMP  = 5;
  localparam int unsigned C_RX_NE   = 6;
  localparam int unsigned C_RX_BRK  = 7;

  typedef struct packed {
    logic [23:0] div;
    logic        glob;
    logic        rx_en;
    logic        tx_en;
    logic        par_en;
    logic        par_even;
    logic        stop2;
    logic [1:0]  len;
  } cfg_t;
endpackage

// File: rtl/uart_fe_fifo.sv
module uart_fe_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [W-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign dout_o  = mem_q[rp_q];
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else if (flush_i) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= din_i;
  end

  // callers must gate on the flags (R4, R7)
  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !flush_i) |-> !full_o);
  assert_no_underflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !flush_i) |-> !empty_o);
  assert_flush_empties_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/uart_fe_irq.sv
module uart_fe_irq #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] ie_i,
  output logic [N-1:0] status_o,
  output logic         irq_o
);
  logic [N-1:0] status_q;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | set_i;
  end

  assign status_o = status_q;
  assign irq_o    = |(status_q & ie_i);

  assert_set_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((status_o & $past(set_i)) == $past(set_i)));
  assert_w1c_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((status_o & $past(clr_i & ~set_i)) == '0));
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && clr_i == '0) |=> $stable(status_o));
endmodule

// File: rtl/uart_fe.sv
module uart_fe
  import uart_fe_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned SMP_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic [1:0]        cfg_len_o,
  output logic              cfg_stop2_o,
  output logic              cfg_par_en_o,
  output logic              cfg_par_even_o,
  output logic [23:0]       cfg_div_o,
  output logic              tx_en_o,
  output logic              rx_en_o,
  output logic [SMP_W-1:0]  sample_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  input  logic              tx_ready_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_stop_err_i,
  input  logic              rx_par_err_i,
  input  logic              rx_break_i
);
  cfg_t               cfg_q;
  logic [SMP_W-1:0]   smp_q;
  logic [NCAUSE-1:0]  ie_q, status, set_v, clr_v;
  logic [31:0]        rdata_q, rdata_d;
  logic               wr, rd, glob, flush;
  logic               tx_full, tx_empty, tx_push, tx_pop;
  logic               rx_full, rx_empty, rx_push, rx_pop, rx_acc, rx_rd;
  logic [7:0]         rx_head;

  assign wr    = req_i && we_i;
  assign rd    = req_i && !we_i;
  assign glob  = cfg_q.glob;
  assign flush = !glob;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0; smp_q <= '0; ie_q <= '0;
    end else if (wr) begin
      case (addr_i)
        A_CFG: cfg_q <= cfg_t'(wdata_i);
        A_SMP: smp_q <= wdata_i[SMP_W-1:0];
        A_IE:  ie_q  <= wdata_i[NCAUSE-1:0];
        default: ;
      endcase
    end
  end

  assign tx_push    = wr && addr_i == A_TXD && glob && !tx_full;
  assign tx_valid_o = glob && cfg_q.tx_en && !tx_empty;
  assign tx_pop     = tx_valid_o && tx_ready_i;
  assign rx_acc     = rx_valid_i && glob && cfg_q.rx_en;
  assign rx_push    = rx_acc && !rx_full;
  assign rx_rd      = rd && addr_i == A_RXD;
  assign rx_pop     = rx_rd && !rx_empty;

  uart_fe_fifo #(.W(CHAR_W), .DEPTH(DEPTH)) u_txq (
    .clk_i, .rst_ni, .flush_i(flush), .push_i(tx_push), .din_i(wdata_i[7:0]),
    .pop_i(tx_pop), .dout_o(tx_data_o), .full_o(tx_full), .empty_o(tx_empty));

  uart_fe_fifo #(.W(CHAR_W), .DEPTH(DEPTH)) u_rxq (
    .clk_i, .rst_ni, .flush_i(flush), .push_i(rx_push), .din_i(rx_data_i),
    .pop_i(rx_pop), .dout_o(rx_head), .full_o(rx_full), .empty_o(rx_empty));

  always_comb begin
    set_v            = '0;
    set_v[C_TX_OVR]  = wr && addr_i == A_TXD && glob && tx_full;
    set_v[C_RX_STOP] = rx_acc && rx_stop_err_i;
    set_v[C_RX_PAR]  = rx_acc && rx_par_err_i;
    set_v[C_RX_OVR]  = rx_acc && rx_full;
    set_v[C_RX_UND]  = rx_rd && rx_empty;
    set_v[C_TX_EMP]  = tx_empty;
    set_v[C_RX_NE]   = !rx_empty;
    set_v[C_RX_BRK]  = rx_acc && rx_break_i;
  end
  assign clr_v = (wr && addr_i == A_STAT) ? wdata_i[NCAUSE-1:0] : '0;

  uart_fe_irq #(.N(NCAUSE)) u_irq (
    .clk_i, .rst_ni, .set_i(set_v), .clr_i(clr_v), .ie_i(ie_q),
    .status_o(status), .irq_o(irq_o));

  always_comb begin
    rdata_d = '0;
    case (addr_i)
      A_CFG:  rdata_d = cfg_q;
      A_SMP:  rdata_d[SMP_W-1:0] = smp_q;
      A_RXD:  rdata_d[8:0] = rx_empty ? 9'h000 : {1'b1, rx_head};
      A_INFO: rdata_d[3:0] = {tx_empty, tx_full, rx_empty, rx_full};
      A_IE:   rdata_d[NCAUSE-1:0] = ie_q;
      A_STAT: rdata_d[NCAUSE-1:0] = status;
      A_PEND: rdata_d[NCAUSE-1:0] = status & ie_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rdata_d;
  end
  assign rdata_o = rdata_q;

  assign cfg_len_o      = cfg_q.len;
  assign cfg_stop2_o    = cfg_q.stop2;
  assign cfg_par_en_o   = cfg_q.par_en;
  assign cfg_par_even_o = cfg_q.par_even;
  assign cfg_div_o      = cfg_q.div;
  assign tx_en_o        = glob && cfg_q.tx_en;
  assign rx_en_o        = glob && cfg_q.rx_en;
  assign sample_o       = smp_q;

  assert_valid_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop |=> rdata_o[8]);
  assert_empty_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rd && rx_empty) |=> (rdata_o == 32'h0 && status[C_RX_UND]));
  assert_overrun_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_acc && rx_full) |=> status[C_RX_OVR]);
  assert_idle_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glob |=> (!tx_valid_o || $past(wr && addr_i == A_CFG)));
endmodule

// File: tb/uart_fe_test.sv
`timescale 1ns/1ps
module uart_fe_test;
  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq, stop2, par_en, par_even, tx_en, rx_en, tx_valid;
  logic [1:0] len;
  logic [23:0] div;
  logic [15:0] smp;
  logic [7:0] tx_data;
  logic tx_ready = 0, rx_valid = 0, e_stop = 0, e_par = 0, e_brk = 0;
  logic [7:0] rx_data = 0;
  int vectors = 0, fails = 0, cyc = 0;
  logic [7:0] txq[$], rxq[$];

  always #2 clk = ~clk;

  uart_fe uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .cfg_len_o(len),
    .cfg_stop2_o(stop2), .cfg_par_en_o(par_en), .cfg_par_even_o(par_even),
    .cfg_div_o(div), .tx_en_o(tx_en), .rx_en_o(rx_en), .sample_o(smp),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_stop_err_i(e_stop),
    .rx_par_err_i(e_par), .rx_break_i(e_brk));

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] info_exp(int rn, int tn);
    return {28'h0, tn == 0, tn == 16, rn == 0, rn == 16};
  endfunction

  task automatic bus_wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic bus_rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata;
  endtask

  task automatic rx_push(logic [7:0] d, logic s, logic p, logic b);
    @(negedge clk); rx_valid = 1; rx_data = d; e_stop = s; e_par = p; e_brk = b;
    @(negedge clk); rx_valid = 0; e_stop = 0; e_par = 0; e_brk = 0;
  endtask

  task automatic tx_take(string r, logic [7:0] exp);
    @(negedge clk);
    check(r, {31'h0, tx_valid}, 32'h1);
    check(r, {24'h0, tx_data}, {24'h0, exp});
    tx_ready = 1;
    @(negedge clk); tx_ready = 0;
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 irq", {31'h0, irq}, 0);
    bus_rd(4'd0, d); check("R1 cfg", d, 0);
    bus_rd(4'd7, d); check("R1 ie", d, 0);
    bus_rd(4'd6, d); check("R1 info", d, 32'h0A);
    bus_rd(4'd9, d); check("R1 status", d, 32'h20);

    // R2 fields, tx/rx enables off
    bus_wr(4'd0, 32'h0001239D);
    @(negedge clk);
    check("R2 len", {30'h0, len}, 1);
    check("R2 stop2/par", {29'h0, stop2, par_en, par_even}, 32'h7);
    check("R2 div", {8'h0, div}, 32'h123);
    check("R2 en", {30'h0, tx_en, rx_en}, 0);
    bus_rd(4'd0, d); check("R2 readback", d, 32'h0001239D);

    bus_wr(4'd2, 32'h12345678);
    bus_rd(4'd2, d); check("R14 readback", d, 32'h5678);
    check("R14 sample_o", {16'h0, smp}, 32'h5678);

    // R4 overflow with transmit engine disabled
    for (int i = 0; i < 17; i++) bus_wr(4'd4, 32'h40 + i);
    check("R3 tx_valid gated by tx_en", {31'h0, tx_valid}, 0);
    bus_rd(4'd6, d); check("R9 info tx full", d, 32'h6);
    bus_rd(4'd9, d); check("R4 overrun latched", d, 32'h21);
    bus_wr(4'd9, 32'hFF);
    bus_rd(4'd9, d); check("R10 clear all", d, 32'h00);
    bus_wr(4'd0, 32'h000123E3);
    for (int i = 0; i < 16; i++) tx_take("R3 order", 8'h40 + 8'(i));
    @(negedge clk); check("R4 17th dropped", {31'h0, tx_valid}, 0);
    bus_rd(4'd9, d); check("R11 tx empty reasserts", d, 32'h20);

    // R5/R7 receive queue
    for (int i = 0; i < 17; i++) rx_push(8'h80 + 8'(i), 0, 0, 0);
    bus_rd(4'd6, d); check("R9 info rx full", d, 32'h9);
    bus_rd(4'd9, d); check("R7 overrun latched", d, 32'h68);
    for (int i = 0; i < 16; i++) begin
      bus_rd(4'd5, d); check("R5 rx data", d, 32'h180 + i);
    end
    bus_rd(4'd5, d); check("R6 empty read", d, 0);
    bus_rd(4'd9, d); check("R6 underrun latched", d, 32'h78);
    bus_wr(4'd9, 32'hFF);
    bus_rd(4'd9, d); check("R10 clear", d, 32'h20);

    // R8 error flags, R10 selective clear, R11 rx level
    rx_push(8'h55, 1, 1, 1);
    bus_rd(4'd9, d); check("R8 error causes", d, 32'hE6);
    bus_wr(4'd9, 32'h04);
    bus_rd(4'd9, d); check("R10 only bit2 cleared", d, 32'hE2);
    bus_wr(4'd9, 32'h40);
    bus_rd(4'd9, d); check("R11 rx nonempty reasserts", d, 32'hE2);
    bus_rd(4'd5, d); check("R5 char with errors", d, 32'h155);
    bus_wr(4'd9, 32'h40);
    bus_rd(4'd9, d); check("R10 bit6 cleared", d, 32'hA2);
    bus_wr(4'd9, 32'hFF);

    // R12 interrupt
    bus_wr(4'd7, 32'h10);
    check("R12 irq low", {31'h0, irq}, 0);
    bus_rd(4'd11, d); check("R12 pending none", d, 0);
    bus_rd(4'd5, d);
    check("R12 irq high", {31'h0, irq}, 1);
    bus_rd(4'd11, d); check("R12 pending", d, 32'h10);
    bus_wr(4'd7, 32'h0);
    check("R12 masked", {31'h0, irq}, 0);
    bus_wr(4'd9, 32'h10);
    bus_wr(4'd7, 32'h20);
    check("R12 tx empty irq", {31'h0, irq}, 1);
    bus_wr(4'd7, 32'h0);

    // R13 global disable
    bus_wr(4'd0, 32'h000123C3);
    for (int i = 0; i < 3; i++) bus_wr(4'd4, 32'hA0 + i);
    rx_push(8'h11, 0, 0, 0); rx_push(8'h22, 0, 0, 0);
    bus_rd(4'd6, d); check("R9 both nonempty", d, 0);
    bus_wr(4'd0, 32'h00012363);
    @(negedge clk);
    check("R13 engines idle", {29'h0, tx_en, rx_en, tx_valid}, 0);
    bus_rd(4'd6, d); check("R13 flushed", d, 32'hA);
    rx_push(8'h33, 0, 0, 0);
    bus_wr(4'd4, 32'h44);
    bus_rd(4'd6, d); check("R13 ignored while off", d, 32'hA);
    bus_wr(4'd0, 32'h000123E3);
    @(negedge clk);
    check("R13 nothing after enable", {31'h0, tx_valid}, 0);
    bus_rd(4'd5, d); check("R13 rx empty after enable", d, 0);

    // random mix against queue model
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 3);
      logic [7:0] v = 8'($urandom);
      case (op)
        0: begin bus_wr(4'd4, {24'h0, v}); if (txq.size() < 16) txq.push_back(v); end
        1: begin rx_push(v, 0, 0, 0); if (rxq.size() < 16) rxq.push_back(v); end
        2: begin
          bus_rd(4'd5, d);
          if (rxq.size() > 0) check("R5 random", d, {23'h0, 1'b1, rxq.pop_front()});
          else check("R6 random", d, 0);
        end
        default: begin
          if (txq.size() > 0) tx_take("R3 random", txq.pop_front());
          else begin @(negedge clk); check("R3 random idle", {31'h0, tx_valid}, 0); end
        end
      endcase
      if (it % 8 == 7) begin
        bus_rd(4'd6, d); check("R9 random", d, info_exp(rxq.size(), txq.size()));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule